// File: doc/BRIEF.md
# Bus Wake-up Mode Controller

This block is the digital mode and wake-up controller of a high-speed CAN transceiver. A standby select input picks between a normal mode and a low-power standby mode. In normal mode the transmitter may drive the bus, the receive output follows the digitised bus level, and the split reference that holds the recessive common-mode level is switched on. In standby mode the transmitter, the normal receiver and the split reference are all off. A low-power path watches the bus and signals a wake-up request on the receive output once dominant activity has lasted long enough.

The bus level arrives already sampled, one bit per clock, with 1 meaning dominant. A digital filter counts consecutive dominant samples, and only a run longer than the filter time is reported. A report is held while the bus stays dominant and drops after the first recessive sample. A wake-up report never changes the mode. Only the controller, by pulling the select input low, starts the return to normal mode, and that return completes after a fixed settling delay.

One parameter chooses between two wake-up variants. The unconditioned variant counts from the first standby cycle. The gated variant first needs one recessive sample after standby entry, so a bus that is stuck dominant cannot hold every node awake. All times are in clock cycles.

Top module: `bus_wake_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block is in standby: receive output high, transmitter enable, receiver select and split enable low. The gated variant's recessive-seen flag starts cleared, so it does not report a bus that is dominant from reset until a recessive sample has been seen.
- R2: In the first cycle after a clock edge that samples the select input high, the transmitter enable, receiver select and split enable are low whatever the transmit input is. In the cycle in which the select input first goes high, the normal outputs are still shown.
- R3: In normal mode the receive output is the inverse of the bus-dominant input, the transmitter enable is the inverse of the transmit input (transmit low requests dominant), and the receiver select and split enable are high. All of these follow their inputs within the same cycle.
- R4: When the select input is sampled low at edge k and stays low, normal mode starts at edge k+NM_DELAY_CYC. Before that edge the block keeps its full standby behaviour, including the receive output.
- R5: A high sample on the select input during the settling delay returns the block to standby. The next low sample restarts the full delay.
- R6: In standby a wake-up is qualified at the edge that samples the bus dominant for the (FILT_CYC+1)-th consecutive time. From the next cycle the receive output is low. It stays low while the bus stays dominant and goes high in the cycle after the first recessive sample.
- R7: A dominant run of FILT_CYC samples or fewer is rejected. Any recessive sample restarts the count.
- R8: Unconditioned variant (GATED=0): if standby is entered while the bus is dominant, counting starts at the first standby edge. The receive output is high for FILT_CYC+1 cycles and then goes low.
- R9: Gated variant (GATED=1): no wake-up is reported until the bus has been sampled recessive in standby. The flag that records this is cleared whenever the block is in normal mode.
- R10: A qualified wake-up does not leave standby. While the select input stays high the drivers stay off and the report is held.
- R11: If the select input is sampled low at the same edge at which a wake-up is qualified, the receive output is low throughout the settling delay while the bus stays dominant. After the delay it follows the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | Mode select: 1 standby, 0 normal |
| txd_i | input | 1 | Transmit data: 0 requests dominant |
| bus_dom_i | input | 1 | Sampled bus comparator: 1 dominant, 0 recessive |
| rxd_o | output | 1 | Receive data or wake-up report: 0 dominant or wake-up |
| tx_en_o | output | 1 | Transmitter drive enable (dominant request) |
| rx_norm_o | output | 1 | Selects the normal receiver path |
| split_en_o | output | 1 | Enables the split common-mode reference |

## Verification
Two functions can act at the same clock edge: the filter qualifies a wake-up while the select input is sampled low and the settling delay starts. The bench provokes this by sending the dominant run that ends qualification in exactly the cycle that lowers the select input. It then expects the receive output to be low during the whole delay, to rise after the bus goes recessive and to follow the bus once normal mode begins. Both variants are driven by the same stimulus, so the gated variant's blocking of a bus that is dominant at standby entry is judged against the unconditioned variant's glitch in the same cycles.

// File: rtl/bus_wake_pkg.sv
`timescale 1ns/1ps
package bus_wake_pkg;
   typedef enum logic [1:0] {
      MODE_STBY = 2'd0,
      MODE_ARM  = 2'd1,
      MODE_NORM = 2'd2
   } wake_mode_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction
endpackage

// File: rtl/bus_wake_mode_seq.sv
`timescale 1ns/1ps
module bus_wake_mode_seq
   import bus_wake_pkg::*;
#(
   parameter int unsigned NM_DELAY_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   output logic normal_o
);
   localparam int unsigned DLY_W = cnt_width(NM_DELAY_CYC);
   localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(NM_DELAY_CYC - 1);

   wake_mode_e       mode_q;
   logic [DLY_W-1:0] dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_STBY;
         dly_q  <= '0;
      end else begin
         case (mode_q)
            MODE_STBY: begin
               if (!stb_i) begin
                  mode_q <= MODE_ARM;
                  dly_q  <= '0;
               end
            end
            MODE_ARM: begin
               if (stb_i) begin
                  mode_q <= MODE_STBY;
               end else if (dly_q == DLY_LAST) begin
                  mode_q <= MODE_NORM;
               end else begin
                  dly_q <= dly_q + 1'b1;
               end
            end
            MODE_NORM: begin
               if (stb_i) mode_q <= MODE_STBY;
            end
            default: mode_q <= MODE_STBY;
         endcase
      end
   end

   assign normal_o = (mode_q == MODE_NORM);
endmodule

// File: rtl/bus_wake_filter.sv
`timescale 1ns/1ps
module bus_wake_filter
   import bus_wake_pkg::*;
#(
   parameter int unsigned FILT_CYC = 500,
   parameter bit          GATED    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stby_i,
   input  logic bus_dom_i,
   output logic wake_o
);
   localparam int unsigned CNT_W = cnt_width(FILT_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FILT_CYC);

   logic [CNT_W-1:0] run_q;
   logic             wake_q;
   logic             arm;

   generate
      if (GATED) begin : g_gated
         logic rec_seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          rec_seen_q <= 1'b0;
            else if (!stby_i)    rec_seen_q <= 1'b0;
            else if (!bus_dom_i) rec_seen_q <= 1'b1;
         end
         assign arm = rec_seen_q;
      end else begin : g_free
         assign arm = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         wake_q <= 1'b0;
      end else if (!stby_i || !bus_dom_i) begin
         run_q  <= '0;
         wake_q <= 1'b0;
      end else if (run_q == CNT_FULL) begin
         wake_q <= wake_q | arm;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign wake_o = wake_q;
endmodule

// File: rtl/bus_wake_pin_mux.sv
`timescale 1ns/1ps
module bus_wake_pin_mux (
   input  logic normal_i,
   input  logic wake_i,
   input  logic txd_i,
   input  logic bus_dom_i,
   output logic rxd_o,
   output logic tx_en_o,
   output logic rx_norm_o,
   output logic split_en_o
);
   always_comb begin
      if (normal_i) begin
         rxd_o   = ~bus_dom_i;
         tx_en_o = ~txd_i;
      end else begin
         rxd_o   = ~wake_i;
         tx_en_o = 1'b0;
      end
      rx_norm_o  = normal_i;
      split_en_o = normal_i;
   end
endmodule

// File: rtl/bus_wake_ctrl.sv
`timescale 1ns/1ps
module bus_wake_ctrl #(
   parameter int unsigned FILT_CYC     = 500,
   parameter int unsigned NM_DELAY_CYC = 2000,
   parameter bit          GATED        = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   input  logic txd_i,
   input  logic bus_dom_i,
   output logic rxd_o,
   output logic tx_en_o,
   output logic rx_norm_o,
   output logic split_en_o
);
   generate
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("FILT_CYC must be at least 1");
      end
      if (NM_DELAY_CYC < 1) begin : g_bad_dly
         $error("NM_DELAY_CYC must be at least 1");
      end
   endgenerate

   logic normal;
   logic wake;

   bus_wake_mode_seq #(.NM_DELAY_CYC(NM_DELAY_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_i    (stb_i),
      .normal_o (normal)
   );

   bus_wake_filter #(.FILT_CYC(FILT_CYC), .GATED(GATED)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .stby_i    (~normal),
      .bus_dom_i (bus_dom_i),
      .wake_o    (wake)
   );

   bus_wake_pin_mux u_mux (
      .normal_i   (normal),
      .wake_i     (wake),
      .txd_i      (txd_i),
      .bus_dom_i  (bus_dom_i),
      .rxd_o      (rxd_o),
      .tx_en_o    (tx_en_o),
      .rx_norm_o  (rx_norm_o),
      .split_en_o (split_en_o)
   );
endmodule

// File: rtl/bus_wake_ctrl_chk.sv
`timescale 1ns/1ps
module bus_wake_ctrl_chk #(
   parameter int unsigned FILT_CYC     = 500,
   parameter int unsigned NM_DELAY_CYC = 2000,
   parameter bit          GATED        = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic stb_i,
   input logic txd_i,
   input logic bus_dom_i,
   input logic rxd_o,
   input logic tx_en_o,
   input logic rx_norm_o,
   input logic split_en_o
);
   localparam int unsigned LOW_W = $clog2(NM_DELAY_CYC + 2);
   localparam int unsigned DOM_W = $clog2(FILT_CYC + 2);

   logic [LOW_W-1:0] low_run;
   logic [DOM_W-1:0] dom_run;
   logic             rec_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         dom_run  <= '0;
         rec_seen <= 1'b0;
      end else begin
         if (stb_i) low_run <= '0;
         else if (low_run <= LOW_W'(NM_DELAY_CYC)) low_run <= low_run + 1'b1;
         if (!bus_dom_i) dom_run <= '0;
         else if (dom_run <= DOM_W'(FILT_CYC)) dom_run <= dom_run + 1'b1;
         if (rx_norm_o) rec_seen <= 1'b0;
         else if (!bus_dom_i) rec_seen <= 1'b1;
      end
   end

   AST_STBY_DRIVERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stb_i) |-> (!tx_en_o && !split_en_o && !rx_norm_o)); // R2
   AST_NORM_RX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      split_en_o |-> (rxd_o == !bus_dom_i)); // R3
   AST_NORM_TX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      split_en_o |-> (tx_en_o == !txd_i)); // R3
   AST_DELAY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      split_en_o |-> (low_run > LOW_W'(NM_DELAY_CYC))); // R4
   AST_WAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_norm_o && !rxd_o) |-> (dom_run > DOM_W'(FILT_CYC))); // R6
   AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_norm_o && !rxd_o && bus_dom_i) |=> (rx_norm_o || !rxd_o)); // R10

   generate
      if (GATED) begin : g_gate_chk
         AST_GATE_NEEDS_REC: assert property (@(posedge clk) disable iff (!rst_n)
            (!rx_norm_o && !rxd_o) |-> rec_seen); // R9
      end
   endgenerate
endmodule

bind bus_wake_ctrl bus_wake_ctrl_chk #(
   .FILT_CYC(FILT_CYC), .NM_DELAY_CYC(NM_DELAY_CYC), .GATED(GATED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .txd_i(txd_i),
   .bus_dom_i(bus_dom_i), .rxd_o(rxd_o), .tx_en_o(tx_en_o),
   .rx_norm_o(rx_norm_o), .split_en_o(split_en_o)
);

// File: tb/tb_bus_wake_ctrl.sv
`timescale 1ns/1ps
module tb_bus_wake_ctrl;
   localparam int F = 6;
   localparam int D = 4;

   typedef struct {
      logic  ru;
      logic  rg;
      logic  tx;
      logic  nm;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stb = 1'b0, txd = 1'b0, bus = 1'b1;
   logic rxd_u, tx_u, rn_u, sp_u;
   logic rxd_g, tx_g, rn_g, sp_g;
   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   bus_wake_ctrl #(.FILT_CYC(F), .NM_DELAY_CYC(D), .GATED(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .stb_i(stb), .txd_i(txd), .bus_dom_i(bus),
      .rxd_o(rxd_u), .tx_en_o(tx_u), .rx_norm_o(rn_u), .split_en_o(sp_u)
   );

   bus_wake_ctrl #(.FILT_CYC(F), .NM_DELAY_CYC(D), .GATED(1'b1)) dut_gtd (
      .clk(clk), .rst_n(rst_n), .stb_i(stb), .txd_i(txd), .bus_dom_i(bus),
      .rxd_o(rxd_g), .tx_en_o(tx_g), .rx_norm_o(rn_g), .split_en_o(sp_g)
   );

   task automatic step(input logic r, input logic s, input logic t, input logic b,
                       input logic eu, input logic eg, input logic etx,
                       input logic enm, input string tag);
      exp_t e;
      @(negedge clk);
      rst_n = r; stb = s; txd = t; bus = b;
      e.ru = eu; e.rg = eg; e.tx = etx; e.nm = enm; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (rxd_u !== e.ru || rxd_g !== e.rg || tx_u !== e.tx || tx_g !== e.tx ||
                rn_u !== e.nm || rn_g !== e.nm || sp_u !== e.nm || sp_g !== e.nm) begin
               n_fail++;
               $display("FAIL %s: rxd u/g=%b/%b tx=%b/%b norm=%b/%b split=%b/%b exp rxd u/g=%b/%b tx=%b norm=%b",
                        e.tag, rxd_u, rxd_g, tx_u, tx_g, rn_u, rn_g, sp_u, sp_g,
                        e.ru, e.rg, e.tx, e.nm);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, queue=%0d exp 0", q.size());
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1 reset state, inputs ignored
      repeat (3) step(0, 0, 0, 1, 1, 1, 0, 0, "R1 reset");
      step(0, 1, 1, 1, 1, 1, 0, 0, "R1 reset");
      // R1/R8: bus dominant from reset, gated flag cleared
      for (int i = 0; i < F + 1; i++) step(1, 1, 0, 1, 1, 1, 0, 0, "R8 filter running");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 0, 1, 0, 0, "R1 gated flag clear");
      step(1, 1, 0, 0, 0, 1, 0, 0, "R6 held until recessive sampled");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 1, 0, 0, "R2 drivers off in standby");
      // R4 settling delay with dominant bus
      for (int i = 0; i < D + 1; i++) step(1, 0, 0, 1, 1, 1, 0, 0, "R4 standby during delay");
      step(1, 0, 0, 1, 0, 0, 1, 1, "R4 normal after delay");
      // R3 normal patterns
      for (int i = 0; i < 8; i++) begin
         logic t, b;
         t = i[0];
         b = i[1] ^ i[2];
         step(1, 0, t, b, ~b, ~b, ~t, 1, "R3 normal follows");
      end
      // R2/R8/R9 standby entry with dominant bus
      step(1, 1, 0, 1, 0, 0, 1, 1, "R2 normal in select cycle");
      for (int i = 0; i < F + 1; i++) step(1, 1, 0, 1, 1, 1, 0, 0, "R8 glitch high");
      for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 0, 1, 0, 0, "R9 gated blocks");
      // R7 short run rejected
      step(1, 1, 0, 0, 0, 1, 0, 0, "R6 recessive clears next");
      for (int i = 0; i < F; i++) step(1, 1, 0, 1, 1, 1, 0, 0, "R7 short run");
      step(1, 1, 0, 0, 1, 1, 0, 0, "R7 reject at limit");
      // R6 qualified run, R10 stays in standby
      for (int i = 0; i < F + 1; i++) step(1, 1, 0, 1, 1, 1, 0, 0, "R6 counting");
      for (int i = 0; i < 8; i++) step(1, 1, 0, 1, 0, 0, 0, 0, "R10 wake stays standby");
      // R7 restart on recessive gap
      step(1, 1, 0, 0, 0, 0, 0, 0, "R6 release");
      for (int i = 0; i < F; i++) step(1, 1, 0, 1, 1, 1, 0, 0, "R7 restart");
      step(1, 1, 0, 0, 1, 1, 0, 0, "R7 restart");
      for (int i = 0; i < F; i++) step(1, 1, 0, 1, 1, 1, 0, 0, "R7 restart");
      step(1, 1, 0, 0, 1, 1, 0, 0, "R7 restart");
      // R11 wake qualifies in the select-low cycle
      for (int i = 0; i < F; i++) step(1, 1, 0, 1, 1, 1, 0, 0, "R11 prefill");
      step(1, 0, 0, 1, 1, 1, 0, 0, "R11 coincide");
      step(1, 0, 0, 1, 0, 0, 0, 0, "R11 wake in delay");
      step(1, 0, 0, 0, 0, 0, 0, 0, "R11 wake in delay");
      step(1, 0, 0, 0, 1, 1, 0, 0, "R11 released in delay");
      step(1, 0, 0, 0, 1, 1, 0, 0, "R11 released in delay");
      step(1, 0, 0, 1, 0, 0, 1, 1, "R11 normal follows bus");
      // R5 abandoned delay restarts
      step(1, 1, 0, 0, 1, 1, 1, 1, "R2 normal in select cycle");
      step(1, 1, 0, 0, 1, 1, 0, 0, "R2 standby");
      step(1, 0, 0, 0, 1, 1, 0, 0, "R5 delay begun");
      step(1, 0, 0, 0, 1, 1, 0, 0, "R5 delay begun");
      step(1, 1, 0, 0, 1, 1, 0, 0, "R5 abort");
      for (int i = 0; i < D + 1; i++) step(1, 0, 0, 0, 1, 1, 0, 0, "R5 full delay again");
      step(1, 0, 0, 0, 1, 1, 1, 1, "R5 normal after full delay");
      wait (q.size() == 0);
      @(negedge clk);
      #2;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule